// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block is an atomic engine that sits beside a small word-organised memory and carries out read-modify-write requests on it without interruption. A requester presents an operation code, an element size, a byte address, data and compare operands, a flag that asks for the prior contents, and two ordering attributes. The unit fetches the addressed location, derives the new contents, stores them back and answers with the value it found there.

The menu covers eight arithmetic and logic updates, an exchange, a conditional exchange on one element and a conditional exchange on a pair of adjacent elements. Each of these works on bytes, halfwords, words or doublewords stored little-endian inside 64-bit memory words. Requests and responses each use a valid/ready handshake. The unit runs one request at a time. A finished response may wait in its output register while the next request runs, unless the ordering attributes forbid this.

Top module: `atomic_engine`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0 and every memory byte reads as zero.
- R2: Opcodes 0 to 3 update memory with, in turn, old plus operand (modulo the element size), old AND NOT operand, old XOR operand, and old OR operand.
- R3: Opcodes 4/5 keep the signed larger/smaller of memory and operand, and opcodes 6/7 keep the unsigned larger/smaller. Both values are taken at the element size, with sign extension for the signed forms.
- R4: reqSize 0/1/2/3 selects an 8/16/32/64-bit element at byte address reqAddr (little-endian). Only those bytes change, and rspData0 returns the element zero-extended to 64 bits.
- R5: For opcodes 0 to 7 with reqRet = 0 the memory update still happens, but rspData0 and rspData1 are zero.
- R6: Opcode 8 (swap) stores the operand reqData0 and always returns the previous element.
- R7: Opcode 9 (compare-and-swap) writes reqData0 only when the element equals reqCmp0, and always returns the previous element.
- R8: Opcode 10 (paired compare-and-swap, reqSize 2 or 3) treats the element at reqAddr and the element directly above it as one unit. Both are written (from reqData0 and reqData1) only if both equal reqCmp0 and reqCmp1. rspData0 and rspData1 return the two previous elements.
- R9: A request that is misaligned, an opcode above 10, or a paired request with reqSize below 2 responds with rspErr = 1 and zero data, and leaves memory unchanged. An address is misaligned when it is not a multiple of the element size, or of twice the element size for a paired request.
- R10: While the response of an acquire request is not yet accepted, reqReady stays 0.
- R11: Without acquire, a new request can be accepted while the previous response is held. Responses leave in acceptance order and stay stable while rspReady is 0.
- R12: A new request is accepted only after the previous write-back. A release request is accepted only when no earlier response is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| reqOp | input | 4 | Operation code |
| reqSize | input | 2 | Element size code |
| reqAddr | input | ADDR_W | Byte address |
| reqData0 | input | 64 | Operand or new value (low element) |
| reqData1 | input | 64 | New value for the upper element of a pair |
| reqCmp0 | input | 64 | Compare value (low element) |
| reqCmp1 | input | 64 | Compare value for the upper element of a pair |
| reqRet | input | 1 | Return prior value for opcodes 0 to 7 |
| reqAcq | input | 1 | Acquire attribute |
| reqRel | input | 1 | Release attribute |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response accepted |
| rspData0 | output | 64 | Prior value (low element) |
| rspData1 | output | 64 | Prior value of the upper element of a pair |
| rspErr | output | 1 | Request rejected |

## Verification
The assertions check the ordering rules on every cycle. No request is accepted while a write-back is still outstanding. An acquire blocks intake until its own response has left. A release is never taken while a response is held. A held response does not change, and error responses carry zero data. The arithmetic results, byte-lane placement, sign handling at each size, the success and failure of single and paired conditional exchanges, and the fact that rejected requests leave memory untouched can only be seen through the bench's scenarios. There, a byte-level model predicts each response and later requests read memory back.

// File: rtl/atomic_pkg.sv
package atomic_pkg;

  localparam int DATA_W = 64;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_CLR  = 4'd1;
  localparam logic [3:0] OP_EOR  = 4'd2;
  localparam logic [3:0] OP_SET  = 4'd3;
  localparam logic [3:0] OP_SMAX = 4'd4;
  localparam logic [3:0] OP_SMIN = 4'd5;
  localparam logic [3:0] OP_UMAX = 4'd6;
  localparam logic [3:0] OP_UMIN = 4'd7;
  localparam logic [3:0] OP_SWP  = 4'd8;
  localparam logic [3:0] OP_CAS  = 4'd9;
  localparam logic [3:0] OP_CASP = 4'd10;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_WAIT} amoStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic capture;
    logic write;
    logic loadRsp;
  } amoStrobeT;

  function automatic logic [DATA_W-1:0] sizeMask(input logic [1:0] s);
    case (s)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic signed [DATA_W-1:0] signExt(input logic [DATA_W-1:0] v,
                                                       input logic [1:0] s);
    case (s)
      2'd0:    return {{56{v[7]}}, v[7:0]};
      2'd1:    return {{48{v[15]}}, v[15:0]};
      2'd2:    return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

endpackage

// File: rtl/atomic_datapath.sv
module atomic_datapath
  import atomic_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  amoStrobeT           stb,
  input  logic [3:0]          reqOp,
  input  logic [1:0]          reqSize,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData0,
  input  logic [DATA_W-1:0]   reqData1,
  input  logic [DATA_W-1:0]   reqCmp0,
  input  logic [DATA_W-1:0]   reqCmp1,
  input  logic                reqRet,
  output logic [DATA_W-1:0]   rspData0,
  output logic [DATA_W-1:0]   rspData1,
  output logic                rspErr
);

  localparam int IDX_W     = ADDR_W - 3;
  localparam int MEM_WORDS = 1 << IDX_W;

  // latched request
  logic [3:0]        rOp;
  logic [1:0]        rSize;
  logic [ADDR_W-1:0] rAddr;
  logic [DATA_W-1:0] rD0, rD1, rC0, rC1;
  logic              rRet;

  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [DATA_W-1:0] old0, old1;

  logic [IDX_W-1:0]  idx, idxHi;
  logic              isPair, hasRet, illegal, misalign, err, pMatch, wrHi;
  logic [3:0]        base, alignMask;
  logic [5:0]        sh;
  logic [DATA_W-1:0] m, elem, opnd, cmpv, res, single;
  logic signed [DATA_W-1:0] sElem, sOpnd;
  logic [DATA_W-1:0] pair0, pair1, pRet0, pRet1;
  logic [DATA_W-1:0] new0, new1, ret0, ret1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rOp <= '0; rSize <= '0; rAddr <= '0; rRet <= 1'b0;
      rD0 <= '0; rD1 <= '0; rC0 <= '0; rC1 <= '0;
    end else if (stb.latchReq) begin
      rOp <= reqOp; rSize <= reqSize; rAddr <= reqAddr; rRet <= reqRet;
      rD0 <= reqData0; rD1 <= reqData1; rC0 <= reqCmp0; rC1 <= reqCmp1;
    end
  end

  assign idx   = rAddr[ADDR_W-1:3];
  assign idxHi = idx | IDX_W'(1);

  always_comb begin
    isPair  = (rOp == OP_CASP);
    hasRet  = rRet || (rOp >= OP_SWP);
    case (rSize)
      2'd0:    base = 4'd0;
      2'd1:    base = 4'd1;
      2'd2:    base = 4'd3;
      default: base = 4'd7;
    endcase
    alignMask = isPair ? {base[2:0], 1'b1} : base;
    misalign  = (rAddr[3:0] & alignMask) != 4'd0;
    illegal   = (rOp > OP_CASP) || (isPair && !rSize[1]);
    err       = illegal || misalign;

    // single-element path
    m     = sizeMask(rSize);
    sh    = {rAddr[2:0], 3'b000};
    elem  = (old0 >> sh) & m;
    opnd  = rD0 & m;
    cmpv  = rC0 & m;
    sElem = signExt(elem, rSize);
    sOpnd = signExt(opnd, rSize);
    case (rOp)
      OP_ADD:  res = elem + opnd;
      OP_CLR:  res = elem & ~opnd;
      OP_EOR:  res = elem ^ opnd;
      OP_SET:  res = elem | opnd;
      OP_SMAX: res = (sElem > sOpnd) ? elem : opnd;
      OP_SMIN: res = (sElem < sOpnd) ? elem : opnd;
      OP_UMAX: res = (elem > opnd) ? elem : opnd;
      OP_UMIN: res = (elem < opnd) ? elem : opnd;
      OP_SWP:  res = opnd;
      OP_CAS:  res = (elem == cmpv) ? opnd : elem;
      default: res = elem;
    endcase
    single = (old0 & ~(m << sh)) | ((res & m) << sh);

    // paired path
    if (!rSize[0]) begin
      pMatch = (old0[31:0] == rC0[31:0]) && (old0[63:32] == rC1[31:0]);
      pair0  = {rD1[31:0], rD0[31:0]};
      pair1  = old1;
      pRet0  = {32'b0, old0[31:0]};
      pRet1  = {32'b0, old0[63:32]};
    end else begin
      pMatch = (old0 == rC0) && (old1 == rC1);
      pair0  = rD0;
      pair1  = rD1;
      pRet0  = old0;
      pRet1  = old1;
    end

    new0 = old0;
    new1 = old1;
    wrHi = 1'b0;
    ret0 = '0;
    ret1 = '0;
    if (!err) begin
      if (isPair) begin
        wrHi = rSize[0];
        ret0 = pRet0;
        ret1 = pRet1;
        if (pMatch) begin
          new0 = pair0;
          new1 = pair1;
        end
      end else begin
        new0 = single;
        ret0 = hasRet ? elem : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
    end else if (stb.write) begin
      mem[idx] <= new0;
      if (wrHi) mem[idxHi] <= new1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      old0 <= '0;
      old1 <= '0;
    end else if (stb.capture) begin
      old0 <= mem[idx];
      old1 <= mem[idxHi];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspData0 <= '0;
      rspData1 <= '0;
      rspErr   <= 1'b0;
    end else if (stb.loadRsp) begin
      rspData0 <= ret0;
      rspData1 <= ret1;
      rspErr   <= err;
    end
  end

endmodule

// File: rtl/atomic_ctrl.sv
module atomic_ctrl
  import atomic_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqAcq,
  input  logic      reqRel,
  input  logic      rspReady,
  output logic      reqReady,
  output logic      rspValid,
  output amoStrobeT stb
);

  amoStateE state, nextState;
  logic     curAcq, rspAcq, slotFree;

  always_comb begin
    stb       = '0;
    nextState = state;
    slotFree  = !rspValid || rspReady;
    reqReady  = (state == S_IDLE) && !(rspValid && (rspAcq || reqRel));
    case (state)
      S_IDLE: if (reqValid && reqReady) begin
        stb.latchReq = 1'b1;
        nextState    = S_READ;
      end
      S_READ: begin
        stb.capture = 1'b1;
        nextState   = S_WRITE;
      end
      S_WRITE: begin
        stb.write = 1'b1;
        if (slotFree) begin
          stb.loadRsp = 1'b1;
          nextState   = S_IDLE;
        end else begin
          nextState = S_WAIT;
        end
      end
      default: if (slotFree) begin
        stb.loadRsp = 1'b1;
        nextState   = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      curAcq   <= 1'b0;
      rspAcq   <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.latchReq) curAcq <= reqAcq;
      if (stb.loadRsp) begin
        rspValid <= 1'b1;
        rspAcq   <= curAcq;
      end else if (rspReady) begin
        rspValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/atomic_engine.sv
module atomic_engine
  import atomic_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [3:0]        reqOp,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [63:0]       reqData0,
  input  logic [63:0]       reqData1,
  input  logic [63:0]       reqCmp0,
  input  logic [63:0]       reqCmp1,
  input  logic              reqRet,
  input  logic              reqAcq,
  input  logic              reqRel,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [63:0]       rspData0,
  output logic [63:0]       rspData1,
  output logic              rspErr
);

  amoStrobeT stb;

  atomic_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAcq(reqAcq),
    .reqRel(reqRel), .rspReady(rspReady), .reqReady(reqReady),
    .rspValid(rspValid), .stb(stb)
  );

  atomic_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .reqOp(reqOp), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqData0(reqData0), .reqData1(reqData1),
    .reqCmp0(reqCmp0), .reqCmp1(reqCmp1), .reqRet(reqRet),
    .rspData0(rspData0), .rspData1(rspData1), .rspErr(rspErr)
  );

endmodule

// File: rtl/atomic_engine_checker.sv
module atomic_engine_checker
  import atomic_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        reqAcq,
  input logic        reqRel,
  input logic        rspValid,
  input logic        rspReady,
  input logic [63:0] rspData0,
  input logic [63:0] rspData1,
  input logic        rspErr,
  input amoStrobeT   stb
);

  logic       accFire, rspFire, inFlight;
  logic [1:0] outstanding, acqLeft;

  assign accFire = reqValid && reqReady;
  assign rspFire = rspValid && rspReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight    <= 1'b0;
      outstanding <= 2'd0;
      acqLeft     <= 2'd0;
    end else begin
      if (accFire) inFlight <= 1'b1;
      else if (stb.write) inFlight <= 1'b0;
      case ({accFire, rspFire})
        2'b10:   outstanding <= outstanding + 2'd1;
        2'b01:   outstanding <= outstanding - 2'd1;
        default: outstanding <= outstanding;
      endcase
      if (accFire && reqAcq) acqLeft <= outstanding + 2'd1 - (rspFire ? 2'd1 : 2'd0);
      else if (rspFire && acqLeft != 2'd0) acqLeft <= acqLeft - 2'd1;
    end
  end

  p_serial_r12: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> !reqReady);

  p_write_owned_r12: assert property (@(posedge clk) disable iff (!rstN)
    stb.write |-> inFlight);

  p_release_r12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqRel) |-> !rspValid);

  p_acquire_r10: assert property (@(posedge clk) disable iff (!rstN)
    (acqLeft != 2'd0) |-> !reqReady);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData0) &&
                                 $stable(rspData1) && $stable(rspErr)));

  p_bounded_r11: assert property (@(posedge clk) disable iff (!rstN)
    outstanding != 2'd3);

  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (rspData0 == 64'd0 && rspData1 == 64'd0));

endmodule

bind atomic_engine atomic_engine_checker chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqAcq(reqAcq), .reqRel(reqRel), .rspValid(rspValid), .rspReady(rspReady),
  .rspData0(rspData0), .rspData1(rspData1), .rspErr(rspErr), .stb(stb)
);

// File: tb/atomic_engine_tb_top.sv
module atomic_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 7;
  localparam int MEM_BYTES  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0, reqReady;
  logic [3:0]        reqOp = '0;
  logic [1:0]        reqSize = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [63:0]       reqData0 = '0, reqData1 = '0, reqCmp0 = '0, reqCmp1 = '0;
  logic              reqRet = 1'b0, reqAcq = 1'b0, reqRel = 1'b0;
  logic              rspValid, rspReady = 1'b1;
  logic [63:0]       rspData0, rspData1;
  logic              rspErr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [63:0] d0;
    logic [63:0] d1;
    logic        err;
    string       tag;
  } expT;

  expT        expQ[$];
  logic [7:0] bm [MEM_BYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_engine #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqSize(reqSize), .reqAddr(reqAddr),
    .reqData0(reqData0), .reqData1(reqData1), .reqCmp0(reqCmp0), .reqCmp1(reqCmp1),
    .reqRet(reqRet), .reqAcq(reqAcq), .reqRel(reqRel),
    .rspValid(rspValid), .rspReady(rspReady),
    .rspData0(rspData0), .rspData1(rspData1), .rspErr(rspErr)
  );

  // ---------------- byte-level reference memory ----------------
  function automatic logic [63:0] rdM(input int a, input int nb);
    logic [63:0] v = '0;
    for (int i = 0; i < nb; i++) v |= 64'(bm[a+i]) << (8*i);
    return v;
  endfunction

  task automatic wrM(input int a, input int nb, input logic [63:0] v);
    for (int i = 0; i < nb; i++) bm[a+i] = v[8*i +: 8];
  endtask

  function automatic logic signed [63:0] toSigned(input logic [63:0] v, input int nb);
    logic [63:0] sb = 64'd1 << (8*nb - 1);
    return $signed((v ^ sb) - sb);
  endfunction

  task automatic modelReq(input int op, input int sz, input int addr,
                          input logic [63:0] d0, input logic [63:0] d1,
                          input logic [63:0] c0, input logic [63:0] c1,
                          input bit ret, input string tag);
    expT e;
    int nb, al;
    bit pair;
    logic [63:0] m, o, x, n, a, b;
    logic signed [63:0] so, sx;
    nb   = 1 << sz;
    pair = (op == 10);
    al   = pair ? 2*nb : nb;
    m    = (nb == 8) ? '1 : (64'd1 << (8*nb)) - 64'd1;
    e.tag = tag; e.d0 = '0; e.d1 = '0; e.err = 1'b0;
    if (op > 10 || (pair && sz < 2) || (addr % al) != 0) begin
      e.err = 1'b1;
    end else if (pair) begin
      a = rdM(addr, nb);
      b = rdM(addr + nb, nb);
      if (a == (c0 & m) && b == (c1 & m)) begin
        wrM(addr, nb, d0);
        wrM(addr + nb, nb, d1);
      end
      e.d0 = a; e.d1 = b;
    end else begin
      o  = rdM(addr, nb);
      x  = d0 & m;
      so = toSigned(o, nb);
      sx = toSigned(x, nb);
      case (op)
        0: n = o + x;
        1: n = o & ~x;
        2: n = o ^ x;
        3: n = o | x;
        4: n = (so > sx) ? o : x;
        5: n = (so < sx) ? o : x;
        6: n = (o > x) ? o : x;
        7: n = (o < x) ? o : x;
        8: n = x;
        default: n = (o == (c0 & m)) ? x : o;
      endcase
      wrM(addr, nb, n & m);
      e.d0 = (ret || op >= 8) ? o : 64'd0;
    end
    expQ.push_back(e);
  endtask

  // ---------------- driver ----------------
  task automatic sendReq(input int op, input int sz, input int addr,
                         input logic [63:0] d0, input logic [63:0] d1,
                         input logic [63:0] c0, input logic [63:0] c1,
                         input bit ret, input bit acq, input bit rel, input string tag);
    @(posedge clk); #2;
    reqOp = 4'(op); reqSize = 2'(sz); reqAddr = ADDR_W'(addr);
    reqData0 = d0; reqData1 = d1; reqCmp0 = c0; reqCmp1 = c1;
    reqRet = ret; reqAcq = acq; reqRel = rel; reqValid = 1'b1;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    modelReq(op, sz, addr, d0, d1, c0, c1, ret, tag);
    @(posedge clk); #2;
    reqValid = 1'b0; reqAcq = 1'b0; reqRel = 1'b0;
  endtask

  task automatic op1(input int op, input int sz, input int addr,
                     input logic [63:0] d0, input string tag);
    sendReq(op, sz, addr, d0, 64'd0, 64'd0, 64'd0, 1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic peek(input int sz, input int addr, input string tag);
    op1(0, sz, addr, 64'd0, tag);
  endtask

  task automatic drain();
    int n = 0;
    while ((expQ.size() != 0 || rspValid) && n < 200) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic waitRsp();
    int n = 0;
    @(negedge clk);
    while (!rspValid && n < 50) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic checkBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  always @(negedge clk) begin
    if (rstN && rspValid && rspReady) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected response: actual d0=%h expected none", rspData0);
      end else begin
        expT e;
        e = expQ.pop_front();
        if (rspData0 !== e.d0 || rspData1 !== e.d1 || rspErr !== e.err) begin
          errors++;
          $display("FAIL %s: actual d0=%h d1=%h err=%0b expected d0=%h d1=%h err=%0b",
                   e.tag, rspData0, rspData1, rspErr, e.d0, e.d1, e.err);
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    for (int i = 0; i < MEM_BYTES; i++) bm[i] = 8'h00;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    checkBit("R1 reset reqReady", reqReady, 1'b1);
    checkBit("R1 reset rspValid", rspValid, 1'b0);
    peek(3, 0,   "R1 memory zero at 0");
    peek(3, 120, "R1 memory zero at 120");

    // swap
    op1(8, 3, 8, 64'h8877_6655_4433_2211, "R6 swap into zero");
    op1(8, 3, 8, 64'h8877_6655_4433_2211, "R6 swap returns previous");

    // arithmetic / logic at several sizes
    op1(0, 1, 10, 64'h0000_0000_0000_FFFF, "R2 add halfword wraps");
    op1(1, 3, 8,  64'h00F0_0000_0000_000F, "R2 bit clear doubleword");
    op1(2, 2, 12, 64'hFFFF_0000_A5A5_5A5A, "R2 xor word upper lanes");
    op1(3, 0, 15, 64'hFFFF_FFFF_FFFF_FF01, "R2 set top byte");
    peek(3, 8, "R4 neighbour bytes untouched");

    // signed / unsigned max and min
    op1(8, 0, 16, 64'h80, "R6 swap byte");
    op1(4, 0, 16, 64'h7F, "R3 smax byte");
    op1(6, 0, 16, 64'h80, "R3 umax byte");
    op1(5, 0, 16, 64'h01, "R3 smin byte keeps negative");
    op1(7, 0, 16, 64'h01, "R3 umin byte");
    op1(5, 3, 24, 64'hFFFF_FFFF_FFFF_FFFF, "R3 smin doubleword negative");
    op1(8, 1, 18, 64'h8000, "R4 swap halfword");
    op1(4, 1, 18, 64'h0001_7FFF, "R3 smax halfword sign extension");
    op1(7, 2, 20, 64'h0000_0001_9000_0000, "R3 umin word");
    peek(3, 16, "R4 lanes at word 16");
    peek(0, 19, "R4 byte read zero-extended");

    // store-only forms
    sendReq(0, 2, 32, 64'd5, 64'd0, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, "R5 add no return");
    sendReq(3, 0, 36, 64'h3C, 64'd0, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, "R5 set no return");
    peek(3, 32, "R5 store-only updated memory");

    // compare-and-swap
    sendReq(9, 2, 32, 64'd9, 64'd0, 64'd5, 64'd0, 1'b0, 1'b0, 1'b0, "R7 cas match");
    sendReq(9, 2, 32, 64'd1, 64'd0, 64'd5, 64'd0, 1'b0, 1'b0, 1'b0, "R7 cas mismatch");
    peek(2, 32, "R7 cas result");

    // paired compare-and-swap
    op1(8, 3, 40, 64'h2222_2222_1111_1111, "R6 setup pair");
    sendReq(10, 2, 40, 64'hAAAA_AAAA, 64'hBBBB_BBBB, 64'h1111_1111, 64'h2222_2222,
            1'b0, 1'b0, 1'b0, "R8 pair32 match");
    sendReq(10, 2, 40, 64'h1, 64'h2, 64'hAAAA_AAAA, 64'h0,
            1'b0, 1'b0, 1'b0, "R8 pair32 half mismatch");
    peek(3, 40, "R8 pair32 contents");
    sendReq(10, 3, 48, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'd0, 64'd0,
            1'b0, 1'b0, 1'b0, "R8 pair64 match");
    sendReq(10, 3, 48, 64'd7, 64'd7, 64'h0123_4567_89AB_CDEF, 64'd1,
            1'b0, 1'b0, 1'b0, "R8 pair64 second mismatch");
    peek(3, 56, "R8 pair64 upper element");

    // rejected requests
    op1(0, 2, 34, 64'd1, "R9 misaligned word");
    sendReq(10, 3, 56, 64'd1, 64'd1, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, "R9 pair64 needs 16 alignment");
    sendReq(10, 1, 60, 64'd1, 64'd1, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, "R9 pair halfword illegal");
    op1(12, 3, 64, 64'd1, "R9 unused opcode");
    peek(3, 32, "R9 memory unchanged at 32");
    peek(3, 56, "R9 memory unchanged at 56");
    peek(3, 64, "R9 memory unchanged at 64");
    drain();

    // acquire blocks intake until its response leaves
    @(posedge clk); #2 rspReady = 1'b0;
    sendReq(0, 3, 64, 64'd1, 64'd0, 64'd0, 64'd0, 1'b1, 1'b1, 1'b0, "R10 acquire add");
    waitRsp();
    repeat (3) begin
      @(negedge clk);
      checkBit("R10 acquire holds reqReady low", reqReady, 1'b0);
    end
    @(posedge clk); #2 rspReady = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checkBit("R10 reqReady after acquire response", reqReady, 1'b1);
    drain();

    // plain request does not block, responses in order
    @(posedge clk); #2 rspReady = 1'b0;
    op1(0, 3, 64, 64'd2, "R11 first held response");
    waitRsp();
    @(negedge clk);
    checkBit("R11 ready while plain response held", reqReady, 1'b1);
    op1(0, 3, 72, 64'd3, "R11 second response in order");
    repeat (4) @(negedge clk);
    checkBit("R11 first response still held", rspValid, 1'b1);
    @(posedge clk); #2 rspReady = 1'b1;
    drain();

    // release waits for held response
    @(posedge clk); #2 rspReady = 1'b0;
    op1(0, 3, 64, 64'd4, "R12 before release");
    waitRsp();
    fork
      sendReq(0, 3, 72, 64'd5, 64'd0, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, "R12 release add");
      begin
        repeat (3) @(negedge clk);
        checkBit("R12 release blocked by held response", reqReady, 1'b0);
        @(posedge clk); #2 rspReady = 1'b1;
      end
    join
    drain();

    // mixed sweep across opcodes, sizes and addresses
    for (int i = 0; i < 44; i++) begin
      int op, sz, nb, al, addr;
      logic [63:0] d0, d1, c0, c1;
      op   = i % 11;
      sz   = (i / 11) % 4;
      nb   = 1 << sz;
      al   = (op == 10) ? 2*nb : nb;
      addr = ((i * 40) % MEM_BYTES) & ~(al - 1);
      d0   = 64'h0123_4567_89AB_CDEF * 64'(i + 1);
      d1   = 64'hF0E1_D2C3_B4A5_9687 ^ 64'(i);
      c0   = (i % 2 == 1 && addr + 2*nb <= MEM_BYTES) ? rdM(addr, nb) : 64'd3;
      c1   = (i % 2 == 1 && addr + 2*nb <= MEM_BYTES) ? rdM(addr + nb, nb) : 64'd3;
      sendReq(op, sz, addr, d0, d1, c0, c1, (i % 3) != 0, 1'b0, 1'b0,
              "R2 R3 R4 R7 R8 sweep");
    end
    for (int a = 0; a < MEM_BYTES; a += 8) peek(3, a, "R4 final memory image");
    drain();

    checkBit("R11 scoreboard empty at end", expQ.size() == 0, 1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule